// File: doc/BRIEF.md
# Page Owner Mapping Table

This block sits beside the L1 cache and TLB of one tile in a tiled multicore that has no hardware coherence. Memory is placed in the L1 caches one page at a time, so every page has exactly one tile that holds its data. The table is a small, fully associative cache of page-to-owner-tile translations. The virtual page number is looked up in parallel with the local L1 and TLB. The table then decides whether the local result may be used, or whether the access goes to another tile. When another tile owns the page, the local lookup and any TLB outcome, including a TLB miss, are thrown away. The virtual page number is then forwarded toward the owner tile's remote-access controller.

When a lookup misses, the table raises a fill request carrying the page number and this tile's ID as the first-touch owner hint. Software or the OS walks its extended page table and answers through the fill port. A fill names either a fixed owner or a replicated read-only mapping. Loads through a replicated mapping stay local. A store through a replicated mapping traps to software, and software may then install this tile as the fixed owner. Barrier and lock-acquire commands each clear the whole table in one cycle and leave the TLB alone. Replacement is round-robin across the entries.

Top module: `page_owner_map`

## Requirements
- R1: After synchronous active-low reset, every entry is invalid and the round-robin pointer selects entry 0, so any valid lookup reports a miss.
- R2: A lookup (load or store) that hits an entry with the replicated bit clear and an owner equal to `tile_id` reports result code 2'b00 (local), with `res_owner` = `tile_id`, `keep_local`=1, `abort_local`=0, `fwd_valid`=0.
- R3: A lookup that hits an entry with the replicated bit clear and an owner other than `tile_id` reports code 2'b01 (remote), with `res_owner` = the stored owner, `abort_local`=1, `fwd_valid`=1, `fwd_vpn` = the looked-up page, and `keep_local`=0. This holds for loads and stores alike.
- R4: A valid lookup that matches no valid entry reports code 2'b10 (miss), with `fill_req`=1, `fill_req_vpn` = the page, `fill_req_owner` = `tile_id`, `abort_local`=1, and `keep_local`, `fwd_valid` and `trap` low.
- R5: A load that hits an entry with the replicated bit set reports code 2'b00 (local) with `res_owner` = `tile_id`, whatever owner field the entry holds.
- R6: A store that hits an entry with the replicated bit set reports code 2'b11 (trap), with `trap`=1, `abort_local`=1, `res_owner` = `tile_id`, and neither a forward nor a fill request.
- R7: A fill whose page is not in the table writes the entry selected by the round-robin pointer, and the pointer then advances by one modulo the entry count. The seventeenth distinct fill into a 16-entry table therefore evicts the first.
- R8: A fill whose page already has a valid entry rewrites that entry in place and leaves the round-robin pointer unchanged.
- R9: `barrier_cmd` or `lock_acq_cmd` invalidates every entry from the next cycle on and leaves the pointer unchanged. A lookup in the same cycle as either command reports a miss.
- R10: A fill presented in the same cycle as an invalidate command is discarded, and the pointer does not move.
- R11: `keep_local` and `fwd_valid` are never high together. When `lk_valid` is low, `keep_local`, `abort_local`, `fwd_valid`, `fill_req` and `trap` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_id | input | TILE_W | ID of this tile |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_is_store | input | 1 | 1 = store, 0 = load |
| barrier_cmd | input | 1 | Barrier reached: invalidate all entries |
| lock_acq_cmd | input | 1 | Lock acquired: invalidate all entries |
| fill_valid | input | 1 | Fill response present |
| fill_vpn | input | VPN_W | Page being filled |
| fill_owner | input | TILE_W | Owner tile for the page |
| fill_repl | input | 1 | Page is mapped as replicated read-only |
| res_kind | output | 2 | 00 local, 01 remote, 10 miss, 11 trap |
| res_owner | output | TILE_W | Tile that serves the access |
| keep_local | output | 1 | Use local L1/TLB result; drop remote path |
| abort_local | output | 1 | Abort L1 lookup and discard TLB outcome |
| fwd_valid | output | 1 | Forward request to remote owner tile |
| fwd_vpn | output | VPN_W | Page sent with the forward |
| fill_req | output | 1 | Request a mapping from software |
| fill_req_vpn | output | VPN_W | Page requested |
| fill_req_owner | output | TILE_W | First-touch owner hint (this tile) |
| trap | output | 1 | Store to replicated page: trap to software |

## Verification
Directed sequences first fill the table to capacity with alternating local and remote owners. One more fill then shows that the oldest slot is the victim. An in-place refill followed by a new fill shows whether the pointer moved. Replicated pages get both a load and a store, which separates the local-read path from the trap. Invalidates are issued together with a lookup and with a fill, which shows whether the clear takes priority. Random traffic on a small page pool keeps hits, evictions, overwrites and clears mixed, and every lookup is compared against a bench model of the table.

// File: rtl/pomt_pkg.sv
// Shared types for the page owner mapping table.
package pomt_pkg;
    typedef enum logic [1:0] {
        RES_LOCAL  = 2'b00,
        RES_REMOTE = 2'b01,
        RES_MISS   = 2'b10,
        RES_TRAP   = 2'b11
    } res_kind_t;
endpackage

// File: rtl/pomt_store.sv
// Entry storage with two associative match ports: one for lookups, one for fills.
// Assumes at most one valid entry per page (the fill path guarantees it).
module pomt_store #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int TILE_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [TILE_W-1:0] wr_owner,
    input  logic              wr_repl,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [VPN_W-1:0]  fl_vpn,
    output logic              lk_hit,
    output logic [TILE_W-1:0] lk_owner,
    output logic              lk_repl,
    output logic              fl_hit,
    output logic [IDX_W-1:0]  fl_idx
);
    logic [ENTRIES-1:0] ent_valid;
    logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
    logic [TILE_W-1:0]  ent_owner [ENTRIES];
    logic [ENTRIES-1:0] ent_repl;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fl_vec;

    // Valid bits: reset and clear-all drop them, a write sets one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else if (clr_all) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= 1'b1;
        end
    end

    // Payload fields: written on fill, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_vpn[wr_idx]   <= wr_vpn;
            ent_owner[wr_idx] <= wr_owner;
            ent_repl[wr_idx]  <= wr_repl;
        end
    end

    // Per-entry comparators for both match ports.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_vec[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
        assign fl_vec[g] = ent_valid[g] && (ent_vpn[g] == fl_vpn);
    end

    // Lookup read-out: AND-OR mux over the one-hot match vector.
    always_comb begin
        lk_owner = '0;
        lk_repl  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_owner = lk_owner | (ent_owner[i] & {TILE_W{lk_vec[i]}});
            lk_repl  = lk_repl | (ent_repl[i] & lk_vec[i]);
        end
        lk_hit = |lk_vec;
    end

    // Fill match: encode the index of the entry that already holds the page.
    always_comb begin
        fl_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_vec[i]) fl_idx = fl_idx | IDX_W'(i);
        end
        fl_hit = |fl_vec;
    end
endmodule

// File: rtl/pomt_alloc.sv
// Write-slot choice for fills: reuse the matching entry, else take the
// round-robin victim and advance the pointer. Assumes fill_go already
// excludes cycles with an invalidate.
module pomt_alloc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_go,
    input  logic             fl_hit,
    input  logic [IDX_W-1:0] fl_idx,
    output logic [IDX_W-1:0] wr_idx
);
    logic [IDX_W-1:0] rr_ptr;

    // Round-robin pointer: moves only when a new entry is allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_go && !fl_hit) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Slot select: in-place update wins over allocation.
    always_comb begin
        wr_idx = fl_hit ? fl_idx : rr_ptr;
    end
endmodule

// File: rtl/pomt_resolve.sv
// Turns the lookup match into the access decision and its strobes.
// Purely combinational; assumes hit is already gated by invalidates.
module pomt_resolve
    import pomt_pkg::*;
#(
    parameter int TILE_W = 4
) (
    input  logic              lk_valid,
    input  logic              lk_is_store,
    input  logic              hit,
    input  logic [TILE_W-1:0] owner,
    input  logic              repl,
    input  logic [TILE_W-1:0] tile_id,
    output res_kind_t         kind,
    output logic [TILE_W-1:0] res_owner,
    output logic              keep_local,
    output logic              abort_local,
    output logic              fwd_valid,
    output logic              fill_req,
    output logic              trap
);
    // Classify the access.
    always_comb begin
        kind      = RES_MISS;
        res_owner = tile_id;
        if (hit) begin
            if (repl) begin
                kind = lk_is_store ? RES_TRAP : RES_LOCAL;
            end else if (owner == tile_id) begin
                kind = RES_LOCAL;
            end else begin
                kind      = RES_REMOTE;
                res_owner = owner;
            end
        end
    end

    // Strobes, all gated by a valid lookup.
    always_comb begin
        keep_local  = lk_valid && (kind == RES_LOCAL);
        abort_local = lk_valid && (kind != RES_LOCAL);
        fwd_valid   = lk_valid && (kind == RES_REMOTE);
        fill_req    = lk_valid && (kind == RES_MISS);
        trap        = lk_valid && (kind == RES_TRAP);
    end
endmodule

// File: rtl/page_owner_map.sv
// Page owner mapping table for one tile. Lookups are answered in the same
// cycle; fills and invalidates take effect at the next clock edge.
// An invalidate takes priority over a same-cycle fill and lookup.
module page_owner_map
    import pomt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int TILE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TILE_W-1:0] tile_id,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_is_store,
    input  logic              barrier_cmd,
    input  logic              lock_acq_cmd,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [TILE_W-1:0] fill_owner,
    input  logic              fill_repl,
    output logic [1:0]        res_kind,
    output logic [TILE_W-1:0] res_owner,
    output logic              keep_local,
    output logic              abort_local,
    output logic              fwd_valid,
    output logic [VPN_W-1:0]  fwd_vpn,
    output logic              fill_req,
    output logic [VPN_W-1:0]  fill_req_vpn,
    output logic [TILE_W-1:0] fill_req_owner,
    output logic              trap
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic              clr_all;
    logic              fill_go;
    logic              st_hit;
    logic [TILE_W-1:0] st_owner;
    logic              st_repl;
    logic              fl_hit;
    logic [IDX_W-1:0]  fl_idx;
    logic [IDX_W-1:0]  wr_idx;
    res_kind_t         kind;

    // Either synchronisation command clears the table; fills yield to it.
    always_comb begin
        clr_all = barrier_cmd | lock_acq_cmd;
        fill_go = fill_valid & ~clr_all;
    end

    pomt_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TILE_W(TILE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .wr_en    (fill_go),
        .wr_idx   (wr_idx),
        .wr_vpn   (fill_vpn),
        .wr_owner (fill_owner),
        .wr_repl  (fill_repl),
        .lk_vpn   (lk_vpn),
        .fl_vpn   (fill_vpn),
        .lk_hit   (st_hit),
        .lk_owner (st_owner),
        .lk_repl  (st_repl),
        .fl_hit   (fl_hit),
        .fl_idx   (fl_idx)
    );

    pomt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill_go (fill_go),
        .fl_hit  (fl_hit),
        .fl_idx  (fl_idx),
        .wr_idx  (wr_idx)
    );

    pomt_resolve #(.TILE_W(TILE_W)) u_resolve (
        .lk_valid    (lk_valid),
        .lk_is_store (lk_is_store),
        .hit         (st_hit & ~clr_all),
        .owner       (st_owner),
        .repl        (st_repl),
        .tile_id     (tile_id),
        .kind        (kind),
        .res_owner   (res_owner),
        .keep_local  (keep_local),
        .abort_local (abort_local),
        .fwd_valid   (fwd_valid),
        .fill_req    (fill_req),
        .trap        (trap)
    );

    // Output payloads: page carried with forward and fill request.
    always_comb begin
        res_kind       = kind;
        fwd_vpn        = fwd_valid ? lk_vpn : '0;
        fill_req_vpn   = fill_req ? lk_vpn : '0;
        fill_req_owner = tile_id;
    end
endmodule

// File: rtl/pomt_checker.sv
// Protocol checks on the page owner mapping table's ports.
module pomt_checker
    import pomt_pkg::*;
#(
    parameter int TILE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TILE_W-1:0] tile_id,
    input logic              lk_valid,
    input logic              lk_is_store,
    input logic              barrier_cmd,
    input logic              lock_acq_cmd,
    input logic [1:0]        res_kind,
    input logic [TILE_W-1:0] res_owner,
    input logic              keep_local,
    input logic              abort_local,
    input logic              fwd_valid,
    input logic              fill_req,
    input logic              trap
);
    // R11
    local_fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(keep_local && fwd_valid));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(keep_local || abort_local || fwd_valid || fill_req || trap));

    // R3
    remote_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (abort_local && res_owner != tile_id));

    // R6
    trap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (lk_is_store && !fwd_valid && !fill_req));

    // R9
    inval_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((barrier_cmd || lock_acq_cmd) && lk_valid) |-> res_kind == RES_MISS);

    // R9
    inval_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (barrier_cmd || lock_acq_cmd) |=> (!lk_valid || res_kind == RES_MISS));
endmodule

bind page_owner_map pomt_checker #(.TILE_W(TILE_W)) u_chk (.*);

// File: tb/page_owner_map_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners, then seeded random traffic,
// every lookup compared against a model of the table.
module page_owner_map_bench;
    localparam int N = 16;
    localparam logic [3:0] MY_TILE = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  tile_id;
    logic        lk_valid, lk_is_store, barrier_cmd, lock_acq_cmd;
    logic [19:0] lk_vpn, fill_vpn;
    logic        fill_valid, fill_repl;
    logic [3:0]  fill_owner;
    logic [1:0]  res_kind;
    logic [3:0]  res_owner, fill_req_owner;
    logic        keep_local, abort_local, fwd_valid, fill_req, trap;
    logic [19:0] fwd_vpn, fill_req_vpn;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the table.
    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [3:0]  m_owner [N];
    logic        m_repl  [N];
    int          m_ptr;

    always #2.5 clk = ~clk;

    page_owner_map u_page_owner_map (.*);

    function automatic int model_find(input logic [19:0] v);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic fail_msg(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_fail++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic step(input logic lv, input logic [19:0] v, input logic st,
                        input logic bar, input logic lck,
                        input logic fv, input logic [19:0] fvpn, input logic [3:0] fo,
                        input logic fr, input string tag_in);
        int          idx;
        logic [1:0]  e_kind;
        logic [3:0]  e_own;
        logic        e_keep, e_abort, e_fwd, e_fill, e_trap;
        string       tag;
        logic [10:0] act, exp;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_is_store = st;
        barrier_cmd = bar; lock_acq_cmd = lck;
        fill_valid = fv; fill_vpn = fvpn; fill_owner = fo; fill_repl = fr;
        #1;
        idx = (bar || lck) ? -1 : model_find(v);
        e_own = MY_TILE;
        if (idx < 0) begin
            e_kind = 2'b10; tag = (bar || lck) ? "R9" : "R4";
        end else if (m_repl[idx]) begin
            e_kind = st ? 2'b11 : 2'b00; tag = st ? "R6" : "R5";
        end else if (m_owner[idx] == MY_TILE) begin
            e_kind = 2'b00; tag = "R2";
        end else begin
            e_kind = 2'b01; e_own = m_owner[idx]; tag = "R3";
        end
        if (tag_in != "") tag = tag_in;
        e_keep  = lv && e_kind == 2'b00;
        e_abort = lv && e_kind != 2'b00;
        e_fwd   = lv && e_kind == 2'b01;
        e_fill  = lv && e_kind == 2'b10;
        e_trap  = lv && e_kind == 2'b11;
        n_tests++;
        if (lv) begin
            act = {res_kind, res_owner, keep_local, abort_local, fwd_valid, fill_req, trap};
            exp = {e_kind, e_own, e_keep, e_abort, e_fwd, e_fill, e_trap};
            if (act !== exp) fail_msg(tag, "result", 64'(act), 64'(exp));
            else if (e_fwd && fwd_vpn !== v) fail_msg(tag, "fwd_vpn", 64'(fwd_vpn), 64'(v));
            else if (e_fill && (fill_req_vpn !== v || fill_req_owner !== MY_TILE))
                fail_msg(tag, "fill_req", 64'({fill_req_owner, fill_req_vpn}), 64'({MY_TILE, v}));
        end else begin
            act = {6'd0, keep_local, abort_local, fwd_valid, fill_req, trap};
            if (act !== 11'd0) fail_msg("R11", "idle strobes", 64'(act), 64'd0);
        end
        // R11: local path and forward are exclusive
        n_tests++;
        if (keep_local && fwd_valid) fail_msg("R11", "keep+fwd", 64'd3, 64'd0);
        @(posedge clk);
        if (bar || lck) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else if (fv) begin
            idx = model_find(fvpn);
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_valid[idx] = 1'b1; m_vpn[idx] = fvpn; m_owner[idx] = fo; m_repl[idx] = fr;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        tile_id = MY_TILE;
        rst_n = 1'b0;
        lk_valid = 0; lk_vpn = 0; lk_is_store = 0; barrier_cmd = 0; lock_acq_cmd = 0;
        fill_valid = 0; fill_vpn = 0; fill_owner = 0; fill_repl = 0;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vpn[i] = 0; m_owner[i] = 0; m_repl[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        step(1, 20'd7, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 20'd7, 1, 0, 0, 0, 0, 0, 0, "R1");

        // Fill to capacity, alternating local and remote owners
        for (int i = 0; i < N; i++)
            step(0, 0, 0, 0, 0, 1, 20'(100 + i), (i % 2) ? 4'd9 : MY_TILE, 0, "");
        step(1, 20'd100, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 20'd101, 1, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 20'd115, 0, 0, 0, 0, 0, 0, 0, "R3");

        // R7: seventeenth fill evicts the oldest
        step(0, 0, 0, 0, 0, 1, 20'd116, MY_TILE, 0, "");
        step(1, 20'd100, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 20'd101, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 20'd116, 1, 0, 0, 0, 0, 0, 0, "R7");

        // R8: in-place refill keeps the pointer
        step(0, 0, 0, 0, 0, 1, 20'd101, MY_TILE, 0, "");
        step(1, 20'd101, 1, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 20'd117, 4'd3, 0, "");
        step(1, 20'd101, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 20'd102, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 20'd117, 0, 0, 0, 0, 0, 0, 0, "R8");

        // R9, R10: barrier with same-cycle lookup and fill
        step(1, 20'd102, 0, 1, 0, 1, 20'd200, MY_TILE, 0, "R9");
        step(1, 20'd200, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 20'd103, 0, 0, 0, 0, 0, 0, 0, "R9");

        // R5, R6: replicated page
        step(0, 0, 0, 0, 0, 1, 20'd300, 4'd9, 1, "");
        step(1, 20'd300, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 20'd300, 1, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 20'd300, MY_TILE, 0, "");
        step(1, 20'd300, 1, 0, 0, 0, 0, 0, 0, "R2");

        // R9: lock acquire clears
        step(0, 0, 0, 0, 0, 1, 20'd301, 4'd9, 0, "");
        step(1, 20'd301, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R11");
        step(1, 20'd301, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 20'd300, 1, 0, 0, 0, 0, 0, 0, "R9");

        // Random traffic on a small page pool
        for (int k = 0; k < 4000; k++) begin
            logic inv;
            inv = ($urandom_range(0, 99) < 4);
            step($urandom_range(0, 99) < 80, 20'($urandom_range(0, 23)), 1'($urandom_range(0, 1)),
                 inv && $urandom_range(0, 1) == 0, inv && $urandom_range(0, 1) == 1,
                 $urandom_range(0, 99) < 40, 20'($urandom_range(0, 23)),
                 4'($urandom_range(0, 15)), $urandom_range(0, 99) < 25, "");
        end

        finish_run();
    end
endmodule